// File: doc/BRIEF.md
# Dithered Pulse-Width Generator

This block converts a duty-cycle word, produced each switching period by a digital control loop, into one switch-drive pulse train with a fixed period of `PERIOD` counter ticks. The upper bits of the duty word give the on-time in whole ticks. The low `FRAC_W` bits give a fraction of a tick. The fraction is realised by adding one tick to selected pulses inside a repeating group of 2^FRAC_W periods. After the output filter, the average duty therefore moves in steps of 1/2^FRAC_W of a tick, without a faster counter clock. This keeps the modulator's effective resolution above that of the feedback converter, and so avoids limit cycling between two output levels.

A first-order accumulator spreads the stretched periods evenly across each group. The duty word is sampled only at a period boundary, so a pulse is never truncated or re-triggered in the middle of a period. A one-cycle strobe marks each period start, so the sampling converter can stay in step with the switching. The block is controlled by a three-state machine:
- `ST_IDLE` is disabled, with the output low.
- `ST_ON` is the high phase of a period.
- `ST_OFF` is the low phase of a period.

The transitions are as follows:
- IDLE→ON or IDLE→OFF happens on enable, chosen by whether the computed width is non-zero.
- ON→OFF happens when the tick count reaches the width.
- ON or OFF moves to ON or OFF at the last tick of a period, which is a reload.
- ON or OFF moves to IDLE when enable drops.

Top module: `dpwm_gen`

## Requirements
- R1: While `rst_n` is low, and in every cycle that follows a clock edge at which `en_i` is low, `pwm_o` and `strobe_o` are low and the dither accumulator is cleared to zero.
- R2: `duty_i` is sampled only at a period start. This is the first edge at which `en_i` is high after being disabled, or the edge that ends tick `PERIOD-1`. A change of `duty_i` at any other time has no effect on the current period.
- R3: With integer part N = `duty_i[DUTY_W-1:FRAC_W]` and no stretch, `pwm_o` is high on ticks 0..N-1 of the period and low on the rest. N = 0 gives no pulse at all.
- R4: Once `pwm_o` has fallen inside a period, it stays low until the next period starts.
- R5: The fraction k = `duty_i[FRAC_W-1:0]` is added to an FRAC_W-bit accumulator at each period start, and a period is stretched by one tick exactly when that addition carries out. The accumulator starts at zero after enabling. Over any group of 2^FRAC_W periods with constant k, exactly k periods are stretched. For example, with FRAC_W = 2 and k = 1, the fourth period of the group is stretched, and with k = 2 the second and fourth are.
- R6: The pulse width is min(N + carry, `PERIOD - MIN_OFF`). With `MIN_OFF` = 0, a duty at or above the period gives a continuous high.
- R7: `strobe_o` is high for exactly one cycle, on tick 0 of every period, while enabled.
- R8: Every period lasts exactly `PERIOD` clock cycles while `en_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces the output low at once |
| duty_i | input | DUTY_W | Duty word: integer ticks above, fraction in the low FRAC_W bits |
| pwm_o | output | 1 | Switch drive pulse train |
| strobe_o | output | 1 | One-cycle mark at each period start |

## Verification
The assertions assume that `PERIOD` is at least two and that `rst_n` is released between clock edges. They also assume that `duty_i` and `en_i` are stable around each rising edge. The bench meets these assumptions by changing every input only on the falling edge. The integer part is allowed to exceed the period, because the clamp is part of the behaviour under test. Duty changes are placed deliberately in mid-period and just before a boundary, so the sampling rule is exercised from both sides.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ON   = 2'd1,
        ST_OFF  = 2'd2
    } dpwm_state_e;

endpackage

// File: rtl/dpwm_dither_acc.sv
module dpwm_dither_acc #(
    parameter int FRAC_W = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         load_i,
    input  logic [(FRAC_W>0?FRAC_W:1)-1:0] frac_i,
    output logic                         carry_o
);

    localparam int AW = (FRAC_W > 0) ? FRAC_W : 1;

    generate
        if (FRAC_W == 0) begin : g_nodither
            assign carry_o = 1'b0;
        end else begin : g_dither
            logic [AW-1:0] acc_q;
            logic [AW:0]   sum;

            always_comb begin
                sum     = {1'b0, acc_q} + {1'b0, frac_i};
                carry_o = sum[AW];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    acc_q <= '0;
                end else if (clear_i) begin
                    acc_q <= '0;
                end else if (load_i) begin
                    acc_q <= sum[AW-1:0];
                end
            end

            // R5: accumulator moves only at a period load
            a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!load_i && !clear_i) |=> $stable(acc_q));

            // R1: a disable leaves the accumulator at zero
            a_r1_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
                clear_i |=> (acc_q == '0));
        end
    endgenerate

endmodule

// File: rtl/dpwm_width_calc.sv
module dpwm_width_calc #(
    parameter int INT_W = 5,
    parameter int LIMIT = 16
) (
    input  logic [INT_W-1:0] int_i,
    input  logic             carry_i,
    output logic [INT_W-1:0] width_o
);

    localparam logic [INT_W:0] LIM_V = (INT_W+1)'(LIMIT);

    logic [INT_W:0] sum;

    always_comb begin
        sum = {1'b0, int_i} + {{INT_W{1'b0}}, carry_i};
        if (sum > LIM_V) begin
            width_o = LIM_V[INT_W-1:0];
        end else begin
            width_o = sum[INT_W-1:0];
        end
    end

endmodule

// File: rtl/dpwm_gen.sv
module dpwm_gen
    import dpwm_pkg::*;
#(
    parameter int PERIOD  = 16,
    parameter int FRAC_W  = 2,
    parameter int MIN_OFF = 0,
    parameter int CNT_W   = $clog2(PERIOD),
    parameter int INT_W   = CNT_W + 1,
    parameter int DUTY_W  = INT_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DUTY_W-1:0] duty_i,
    output logic              pwm_o,
    output logic              strobe_o
);

    localparam int            LIMIT  = PERIOD - MIN_OFF;
    localparam int            FW     = (FRAC_W > 0) ? FRAC_W : 1;
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(PERIOD - 1);

    dpwm_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [INT_W-1:0]  width_q, width_d;
    logic [INT_W-1:0]  width_new;
    logic [INT_W-1:0]  cnt_inc;
    logic [FW-1:0]     frac;
    logic              carry;
    logic              load;
    logic              last;

    generate
        if (FRAC_W > 0) begin : g_frac
            assign frac = duty_i[FW-1:0];
        end else begin : g_nofrac
            assign frac = 1'b0;
        end
    endgenerate

    dpwm_dither_acc #(
        .FRAC_W (FRAC_W)
    ) u_dither (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!en_i),
        .load_i  (load),
        .frac_i  (frac),
        .carry_o (carry)
    );

    dpwm_width_calc #(
        .INT_W (INT_W),
        .LIMIT (LIMIT)
    ) u_width (
        .int_i   (duty_i[DUTY_W-1:FRAC_W]),
        .carry_i (carry),
        .width_o (width_new)
    );

    assign last    = (cnt_q == LAST_TICK);
    assign cnt_inc = {1'b0, cnt_q} + INT_W'(1);

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        width_d = width_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) load = 1'b1;
            end
            ST_ON, ST_OFF: begin
                if (!en_i) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (last) begin
                    load = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                    if (state_q == ST_ON && cnt_inc >= width_q) begin
                        state_d = ST_OFF;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (load) begin
            cnt_d   = '0;
            width_d = width_new;
            state_d = (width_new != '0) ? ST_ON : ST_OFF;
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            width_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            width_q <= width_d;
        end
    end

    // output process
    always_comb begin
        pwm_o    = (state_q == ST_ON);
        strobe_o = (state_q != ST_IDLE) && (cnt_q == '0);
    end

    // R1: disable forces the output low on the next cycle
    a_r1_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!pwm_o && !strobe_o));

    // R4: no second rise inside a period
    a_r4_no_rerise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && !last && en_i) |=> (state_q == ST_OFF));

    // R2: width frozen between period boundaries
    a_r2_width_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !last && en_i) |=> $stable(width_q));

    // R7: strobe lasts a single cycle
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    // R8: last tick while running is always followed by tick zero
    a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && last && en_i) |=> strobe_o);

    // R6: high through the final tick only when no off-time is reserved
    a_r6_min_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && last) |-> (MIN_OFF == 0));

endmodule

// File: tb/dpwm_gen_tb.sv
module dpwm_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD  = 16;
    localparam int FRAC_W  = 2;
    localparam int MIN_OFF = 0;
    localparam int CNT_W   = $clog2(PERIOD);
    localparam int INT_W   = CNT_W + 1;
    localparam int DUTY_W  = INT_W + FRAC_W;
    localparam int GROUP   = 1 << FRAC_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [DUTY_W-1:0] duty = '0;
    logic pwm, strobe;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    string req = "R1";

    // reference model state
    int m_active = 0;
    int m_cnt = 0;
    int m_width = 0;
    int m_acc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpwm_gen #(
        .PERIOD  (PERIOD),
        .FRAC_W  (FRAC_W),
        .MIN_OFF (MIN_OFF)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en),
        .duty_i   (duty),
        .pwm_o    (pwm),
        .strobe_o (strobe)
    );

    always @(posedge clk or negedge rst_n) begin
        cycles++;
        if (!rst_n) begin
            m_active = 0; m_cnt = 0; m_width = 0; m_acc = 0;
        end else if (!en) begin
            m_active = 0; m_cnt = 0; m_acc = 0;
        end else if (m_active == 0 || m_cnt == PERIOD - 1) begin
            int n, k, s, w;
            n = int'(duty) >> FRAC_W;
            k = int'(duty) % GROUP;
            s = m_acc + k;
            w = n + ((s >= GROUP) ? 1 : 0);
            m_acc = s % GROUP;
            if (w > PERIOD - MIN_OFF) w = PERIOD - MIN_OFF;
            m_width = w;
            m_cnt = 0;
            m_active = 1;
        end else begin
            m_cnt++;
        end
    end

    function automatic logic exp_pwm();
        return (m_active != 0) && (m_cnt < m_width);
    endfunction

    function automatic logic exp_strobe();
        return (m_active != 0) && (m_cnt == 0);
    endfunction

    task automatic check(string r, string what, int act, int expv);
        vectors++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", r, what, act, expv, cycles);
        end
    endtask

    task automatic step();
        @(negedge clk);
        check(req, "pwm_o", int'(pwm), int'(exp_pwm()));
        check((req == "R7") ? "R7" : req, "strobe_o", int'(strobe), int'(exp_strobe()));
    endtask

    function automatic logic [DUTY_W-1:0] mk(int n, int k);
        return DUTY_W'((n << FRAC_W) | k);
    endfunction

    // R5: one aligned group of periods; high-tick total must be GROUP*n+k
    task automatic run_group(int n, int k);
        int highs = 0;
        int strobes = 0;
        en = 1'b0;
        step();
        en = 1'b1;
        duty = mk(n, k);
        for (int i = 0; i < GROUP * PERIOD; i++) begin
            step();
            if (pwm) highs++;
            if (strobe) strobes++;
        end
        check("R5", "group high ticks", highs, GROUP * n + k);
        check("R8", "strobes per group", strobes, GROUP);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        req = "R1";
        step();
        check("R1", "pwm in reset", int'(pwm), 0);
        step();
        rst_n = 1'b1;
        step();

        // R3: plain integer widths
        req = "R3";
        en = 1'b1;
        duty = mk(5, 0);
        repeat (3 * PERIOD) step();
        duty = mk(0, 0);
        repeat (2 * PERIOD) step();
        duty = mk(1, 0);
        repeat (2 * PERIOD) step();

        // R2: mid-period change ignored until boundary
        req = "R2";
        duty = mk(8, 0);
        repeat (PERIOD + 3) step();
        duty = mk(2, 0);
        step();
        check("R2", "pwm held after mid change", int'(pwm), 1);
        repeat (2 * PERIOD) step();

        // R4: narrow pulse then long low phase
        req = "R4";
        duty = mk(3, 0);
        repeat (2 * PERIOD) step();

        // R5: fractional groups
        req = "R5";
        run_group(4, 1);
        run_group(4, 2);
        run_group(4, 3);
        run_group(0, 1);
        run_group(7, 0);

        // R6: clamp at and above the period
        req = "R6";
        duty = mk(PERIOD, 0);
        repeat (2 * PERIOD) step();
        duty = mk((1 << INT_W) - 1, GROUP - 1);
        repeat (2 * PERIOD) step();
        check("R6", "continuous high", int'(pwm), 1);
        run_group(PERIOD - 1, GROUP - 1);

        // R7: strobe placement with several duties
        req = "R7";
        duty = mk(6, 2);
        repeat (3 * PERIOD) step();

        // R1: disable mid-pulse
        req = "R1";
        duty = mk(12, 0);
        en = 1'b0;
        step();
        en = 1'b1;
        repeat (4) step();
        en = 1'b0;
        step();
        check("R1", "pwm after disable", int'(pwm), 0);
        repeat (5) step();

        // R8: re-enable and run
        req = "R8";
        en = 1'b1;
        duty = mk(9, 1);
        repeat (3 * PERIOD) step();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule